// File: doc/BRIEF.md
# Adaptive Read/Write Mix Arbiter Selector

This block decides which of three prebuilt, history-driven command arbiters steers the memory controller's scheduling. Each candidate arbiter is tuned for one read-to-write command mix: read heavy (two reads per write), balanced (one read per write) and write heavy (one read per two writes). The aim is to issue reads and writes in about the proportion the application produces them, so that neither the read reorder queue nor the write reorder queue backs up.

The selector counts read and write arrivals, one strobe each per cycle, over a fixed window of `WINDOW_LEN` cycles. At the last cycle of each window it classifies the observed proportion without division, loads a select register and clears its tallies. The select index drives a multiplexer over the grant words of the three candidate arbiters. The index can move only at a window boundary, so the multiplexer never switches while a window is in progress.

Top module: `amix_arbiter_select`

## Requirements
- R1: While reset is high, and after it is released until the first window ends, `arb_sel` is 1 (balanced). The encoding is 0 = read heavy, 1 = balanced, 2 = write heavy, and the value 3 never appears.
- R2: A window is `WINDOW_LEN` clock cycles long. The first window begins with the first rising edge at which reset is low, and windows follow one another with no gap. A new selection is visible from the first cycle of the following window.
- R3: With R reads and W writes in a window, not both zero, the selection becomes 0 when 2*R >= 3*W. This includes a window with writes equal to zero.
- R4: If R3 does not apply and 2*W >= 3*R, the selection becomes 2.
- R5: If R3 and R4 do not apply and the window held at least one command, the selection becomes 1.
- R6: A window with no read and no write arrivals leaves the selection unchanged.
- R7: `arb_sel` does not change on any cycle other than the last cycle of a window.
- R8: Arrivals in the last cycle of a window count toward that window. The tallies start from zero in each new window, and nothing carries over.
- R9: `grant_out` equals the slice `cand_grant[i*GRANT_W +: GRANT_W]`, where i is the current `arb_sel`.
- R10: A read strobe and a write strobe that are both high in the same cycle are each counted once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_arrive | input | 1 | One read command arrived this cycle |
| wr_arrive | input | 1 | One write command arrived this cycle |
| cand_grant | input | 3*GRANT_W | Grant words of the three candidate arbiters, slice i belonging to arbiter i |
| arb_sel | output | 2 | Selected arbiter index |
| grant_out | output | GRANT_W | Grant word of the selected arbiter |

## Verification
Two things can fall in the same cycle: an arrival in the last cycle of a window, and the evaluate-and-clear step that closes that window. A read and a write strobe can also coincide. The bench places arrivals only at the tail of some windows and uses fully overlapped read/write patterns in others. It then judges the new selection against counts computed from the requirements. A following window that has different counts shows whether any tally leaked across the boundary. Selections are compared one cycle after each window's last edge and again at mid-window, which catches both early and late switching.

// File: rtl/amix_pkg.sv
package amix_pkg;

    localparam int unsigned NUM_MIX = 3;

    typedef enum logic [1:0] {
        MIX_RD_HEAVY = 2'd0,
        MIX_BALANCED = 2'd1,
        MIX_WR_HEAVY = 2'd2
    } mix_e;

    typedef struct packed {
        logic [31:0] rd;
        logic [31:0] wr;
    } tally_t;

    // Threshold 1.5 done as 2*a >= 3*b, with no divider
    function automatic mix_e classify_mix(input tally_t t, input mix_e prev);
        longint unsigned r2, r3, w2, w3;
        r2 = 2 * longint'(t.rd);
        r3 = 3 * longint'(t.rd);
        w2 = 2 * longint'(t.wr);
        w3 = 3 * longint'(t.wr);
        if (t.rd == 32'd0 && t.wr == 32'd0) return prev;
        if (r2 >= w3) return MIX_RD_HEAVY;
        if (w2 >= r3) return MIX_WR_HEAVY;
        return MIX_BALANCED;
    endfunction

endpackage

// File: rtl/amix_window_timer.sv
module amix_window_timer #(
    parameter int unsigned WINDOW_LEN = 1024
) (
    input  logic clk,
    input  logic rst,
    output logic win_last
);
    localparam int unsigned TW = (WINDOW_LEN > 2) ? $clog2(WINDOW_LEN) : 1;
    localparam logic [TW-1:0] LAST_IDX = TW'(WINDOW_LEN - 1);

    logic [TW-1:0] tick_q;

    assign win_last = (tick_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst)           tick_q <= '0;
        else if (win_last) tick_q <= '0;
        else               tick_q <= tick_q + 1'b1;
    end

    // R2: the position counter stays inside the window
    p_tick_in_window_r2: assert property (@(posedge clk) disable iff (rst)
        tick_q <= LAST_IDX);

    // R2: the cycle after the last one starts a new window
    p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        win_last |=> tick_q == '0);

endmodule

// File: rtl/amix_event_counter.sv
module amix_event_counter #(
    parameter int unsigned MAX_COUNT = 1024,
    parameter int unsigned CW        = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic          clr,
    output logic [CW-1:0] total
);
    logic [CW-1:0] count_q;

    assign total = count_q + CW'(inc);

    always_ff @(posedge clk) begin
        if (rst || clr) count_q <= '0;
        else            count_q <= total;
    end

    // R8: nothing carries over into the next window
    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        clr |=> count_q == '0);

    // R10: each strobe adds exactly one
    p_step_r10: assert property (@(posedge clk) disable iff (rst)
        (!clr && inc) |=> count_q == $past(count_q) + 1'b1);

    p_bounded_r8: assert property (@(posedge clk) disable iff (rst)
        count_q <= CW'(MAX_COUNT));

endmodule

// File: rtl/amix_ratio_select.sv
module amix_ratio_select
    import amix_pkg::*;
#(
    parameter int unsigned CW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          eval,
    input  logic [CW-1:0] rd_total,
    input  logic [CW-1:0] wr_total,
    output mix_e          sel
);
    tally_t tally;
    mix_e   sel_q;
    mix_e   sel_next;

    always_comb begin
        tally.rd = 32'(rd_total);
        tally.wr = 32'(wr_total);
        sel_next = classify_mix(tally, sel_q);
    end

    always_ff @(posedge clk) begin
        if (rst)       sel_q <= MIX_BALANCED;
        else if (eval) sel_q <= sel_next;
    end

    assign sel = sel_q;

    // R7: no switching inside a window
    p_hold_mid_window_r7: assert property (@(posedge clk) disable iff (rst)
        !eval |=> $stable(sel_q));

    // R6: an empty window keeps the choice
    p_empty_keeps_r6: assert property (@(posedge clk) disable iff (rst)
        (eval && rd_total == '0 && wr_total == '0) |=> $stable(sel_q));

    // R1: only three legal codes
    p_legal_code_r1: assert property (@(posedge clk)
        sel_q != 2'd3);

endmodule

// File: rtl/amix_grant_mux.sv
module amix_grant_mux
    import amix_pkg::*;
#(
    parameter int unsigned GRANT_W = 8
) (
    input  logic [NUM_MIX*GRANT_W-1:0] cand_grant,
    input  mix_e                       sel,
    output logic [GRANT_W-1:0]         grant_out
);
    logic [GRANT_W-1:0] slices [NUM_MIX];

    genvar gi;
    generate
        for (gi = 0; gi < NUM_MIX; gi++) begin : g_slice
            assign slices[gi] = cand_grant[gi*GRANT_W +: GRANT_W];
        end
    endgenerate

    always_comb begin
        grant_out = slices[MIX_BALANCED];
        for (int i = 0; i < NUM_MIX; i++) begin
            if (sel == mix_e'(i)) grant_out = slices[i];
        end
    end

endmodule

// File: rtl/amix_arbiter_select.sv
module amix_arbiter_select
    import amix_pkg::*;
#(
    parameter int unsigned WINDOW_LEN = 1024,
    parameter int unsigned GRANT_W    = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       rd_arrive,
    input  logic                       wr_arrive,
    input  logic [NUM_MIX*GRANT_W-1:0] cand_grant,
    output logic [1:0]                 arb_sel,
    output logic [GRANT_W-1:0]         grant_out
);
    localparam int unsigned CW = $clog2(WINDOW_LEN + 1);

    logic          win_last;
    logic [CW-1:0] rd_total;
    logic [CW-1:0] wr_total;
    mix_e          sel;

    amix_window_timer #(.WINDOW_LEN(WINDOW_LEN)) u_timer (
        .clk(clk), .rst(rst), .win_last(win_last)
    );

    amix_event_counter #(.MAX_COUNT(WINDOW_LEN), .CW(CW)) u_rd_cnt (
        .clk(clk), .rst(rst), .inc(rd_arrive), .clr(win_last), .total(rd_total)
    );

    amix_event_counter #(.MAX_COUNT(WINDOW_LEN), .CW(CW)) u_wr_cnt (
        .clk(clk), .rst(rst), .inc(wr_arrive), .clr(win_last), .total(wr_total)
    );

    amix_ratio_select #(.CW(CW)) u_select (
        .clk(clk), .rst(rst), .eval(win_last),
        .rd_total(rd_total), .wr_total(wr_total), .sel(sel)
    );

    amix_grant_mux #(.GRANT_W(GRANT_W)) u_mux (
        .cand_grant(cand_grant), .sel(sel), .grant_out(grant_out)
    );

    assign arb_sel = sel;

    // R1: reset lands on the balanced arbiter
    p_reset_balanced_r1: assert property (@(posedge clk)
        rst |=> arb_sel == 2'd1);

    // R9: output grant follows the selected slice
    always_comb begin
        if (!rst && arb_sel != 2'd3)
            a_grant_slice_r9: assert (grant_out == cand_grant[arb_sel*GRANT_W +: GRANT_W]);
    end

endmodule

// File: tb/amix_arbiter_select_tb.sv
`timescale 1ns/1ps
module amix_arbiter_select_tb;
    localparam int unsigned W  = 32;
    localparam int unsigned GW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rd_arrive = 1'b0;
    logic          wr_arrive = 1'b0;
    logic [3*GW-1:0] cand_grant = {8'hC3, 8'h5A, 8'h17};
    logic [1:0]    arb_sel;
    logic [GW-1:0] grant_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    int exp_q[$];
    int cur_exp = 1;

    always #10 clk = ~clk;

    amix_arbiter_select #(.WINDOW_LEN(W), .GRANT_W(GW)) u_dut (
        .clk(clk), .rst(rst), .rd_arrive(rd_arrive), .wr_arrive(wr_arrive),
        .cand_grant(cand_grant), .arb_sel(arb_sel), .grant_out(grant_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model(input int r, input int w, input int prev);
        if (r == 0 && w == 0) return prev;          // R6
        if (2*r >= 3*w) return 0;                   // R3
        if (2*w >= 3*r) return 2;                   // R4
        return 1;                                   // R5
    endfunction

    int model_prev = 1;

    // Driver: one window; late=1 packs arrivals into the window tail
    task automatic drive_window(input int nr, input int nw, input bit late);
        model_prev = model(nr, nw, model_prev);
        exp_q.push_back(model_prev);
        for (int c = 0; c < W; c++) begin
            if (late) begin
                rd_arrive = (c >= W - nr);
                wr_arrive = (c >= W - nw);
            end else begin
                rd_arrive = (c < nr);
                wr_arrive = (c < nw);
            end
            @(negedge clk);
        end
        rd_arrive = 1'b0;
        wr_arrive = 1'b0;
    endtask

    function automatic int slice_of(input int i);
        return int'(cand_grant[i*GW +: GW]);
    endfunction

    // Monitor: mid-window stability, then new selection after each boundary
    initial begin
        wait (!rst);
        forever begin
            repeat (W/2) @(posedge clk);
            @(negedge clk);
            if (exp_q.size() > 0)
                check("R7 mid-window hold", int'(arb_sel), cur_exp);
            repeat (W - W/2) @(posedge clk);
            @(negedge clk);
            if (exp_q.size() > 0) begin
                cur_exp = exp_q.pop_front();
                check("R2/R3/R4/R5/R6/R8 window result", int'(arb_sel), cur_exp);
                check("R9 grant slice", int'(grant_out), slice_of(cur_exp));
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset select", int'(arb_sel), 1);
        check("R9 grant in reset", int'(grant_out), 8'h5A);
        rst = 1'b0;
        drive_window(20, 10, 1'b0);  // R3, R10 overlapped strobes -> 0
        drive_window(0, 0, 1'b0);    // R6 keep 0
        drive_window(10, 15, 1'b0);  // R4 exact 1.5 -> 2
        drive_window(14, 20, 1'b0);  // R5 -> 1
        drive_window(3, 2, 1'b1);    // R8 tail arrivals, 6>=6 -> 0
        drive_window(0, 1, 1'b1);    // R8 single last-cycle write -> 2
        drive_window(16, 11, 1'b0);  // R5 just under threshold -> 1
        drive_window(0, 0, 1'b1);    // R6 keep 1
        drive_window(5, 0, 1'b0);    // R3 no writes -> 0
        drive_window(32, 32, 1'b0);  // R10 every cycle both -> 1
        repeat (4) @(negedge clk);
        check("R7 hold after last window", int'(arb_sel), 1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule